// File: doc/BRIEF.md
# Multiplexed Bus Write Capture Buffer

This block sits on the memory side of a synchronous processor bus. The bus shares one 64-bit path between addresses and data, and a 9-bit command bus with an even-parity bit travels next to it. On every rising clock edge where the master's valid strobe is high, the block looks at the top command bit to decide whether the beat is a command/address beat or a data beat. A write command beat stores a 36-bit physical address as pending. The next data beat pairs with that address and goes into a small first-in first-out write buffer. The processor can therefore post writes without waiting for memory.

The block tells the master through a ready output whether it can take another write. It drops that output while at least one free entry still remains, so a write already on its way is not lost. Downstream logic drains the stored address/data pairs through a valid/ready port. Malformed beats are dropped and set a sticky error flag, which only reset clears.

Top module: `mbus_wr_capture`

## Requirements
- R1: After reset the buffer is empty (`out_vld` low), `wr_rdy` is high and `err` is low.
- R2: A beat with `bus_vld` low has no effect. The buffer contents, the pending address and `err` all stay as they were.
- R3: A valid beat with `bus_cmd[8]`=0 and `bus_cmd[7]`=1 is a write command. It stores `bus_ad[35:0]` as the pending address. The next valid beat with `bus_cmd[8]`=1 is a data beat: it writes {pending address, `bus_ad`} into the buffer and clears the pending address. The entry shows up on `out_vld`/`out_addr`/`out_data` one edge after the data beat.
- R4: A write command beat whose `bus_ad[63:36]` is not zero sets `err` and is discarded. The pending state does not change.
- R5: Parity is even over the ten bits {`bus_cmd`, `bus_cmdp`}. A valid beat with an odd count of ones sets `err` and is discarded.
- R6: A data beat that arrives with no pending address sets `err` and is dropped.
- R7: Entries leave in arrival order. A transfer happens on an edge where `out_vld` and `out_rdy` are both high. While `out_rdy` is low the head entry stays where it is.
- R8: `wr_rdy` is low whenever one free entry or fewer remains. With 4 entries this means 3 or 4 are occupied.
- R9: A data beat that arrives while all entries are occupied is dropped and sets `err`. The pending address is consumed. The stored entries do not change.
- R10: A valid command beat with `bus_cmd[7]`=0 is not a write. It leaves the pending address as it was.
- R11: A push and a pop on the same edge leave the occupancy unchanged.
- R12: `err`, once set, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_vld | input | 1 | Master drives a valid beat |
| bus_ad | input | 64 | Shared address/data path |
| bus_cmd | input | 9 | Beat command; bit 8 selects data vs command, bit 7 marks a write |
| bus_cmdp | input | 1 | Even-parity bit for `bus_cmd` |
| wr_rdy | output | 1 | Master may issue another write |
| err | output | 1 | Sticky protocol/parity error |
| out_vld | output | 1 | Head entry is available |
| out_rdy | input | 1 | Downstream takes the head entry |
| out_addr | output | 36 | Address of the head entry |
| out_data | output | 64 | Data of the head entry |

## Verification
Every result is due one rising edge after the beat that causes it. A pending address, a new buffer entry with its `out_vld`, a set error and a popped head all become visible after that single edge. `wr_rdy` follows the occupancy at the same edge. The bench drives each beat at a falling edge and moves its own reference model forward one beat at the same moment. It compares every output 1 ns after the following rising edge, so each check falls in exactly the cycle where the result first appears.

// File: rtl/mbus_wr_capture.sv
module mbus_wr_capture #(
  parameter int AW    = 36,
  parameter int DW    = 64,
  parameter int CW    = 9,
  parameter int DEPTH = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_vld,
  input  logic [DW-1:0] bus_ad,
  input  logic [CW-1:0] bus_cmd,
  input  logic          bus_cmdp,
  output logic          wr_rdy,
  output logic          err,
  output logic          out_vld,
  input  logic          out_rdy,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] FULL_N  = NW'(DEPTH);
  localparam logic [NW-1:0] RDY_LIM = NW'(DEPTH - 1);
  localparam logic [PW-1:0] LAST    = PW'(DEPTH - 1);

  logic          pend_vld;
  logic [AW-1:0] pend_addr;
  logic [AW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;

  wire par_ok   = ~^{bus_cmd, bus_cmdp};
  wire is_data  = bus_cmd[CW-1];
  wire is_wr    = bus_cmd[CW-2];
  wire hi_zero  = (bus_ad[DW-1:AW] == '0);
  wire full     = (cnt == FULL_N);
  wire cmd_ok   = bus_vld & par_ok & ~is_data;
  wire data_bt  = bus_vld & par_ok & is_data;
  wire addr_tk  = cmd_ok & is_wr & hi_zero;
  wire push     = data_bt & pend_vld & ~full;
  wire pop      = out_vld & out_rdy;
  wire err_now  = bus_vld & (~par_ok
                           | (~is_data & is_wr & ~hi_zero)
                           | (is_data & (~pend_vld | full)));

  assign out_vld  = (cnt != '0);
  assign wr_rdy   = (cnt < RDY_LIM);
  assign out_addr = mem_a[rp];
  assign out_data = mem_d[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      err       <= 1'b0;
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
    end else begin
      if (err_now) err <= 1'b1;
      if (addr_tk) begin
        pend_vld  <= 1'b1;
        pend_addr <= bus_ad[AW-1:0];
      end else if (data_bt) begin
        pend_vld  <= 1'b0;
      end
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + NW'(push) - NW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_a[wp] <= pend_addr;
      mem_d[wp] <= bus_ad;
    end
  end
endmodule

// File: rtl/mbus_wr_capture_chk.sv
module mbus_wr_capture_chk #(
  parameter int AW = 36,
  parameter int DW = 64,
  parameter int CW = 9
)(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_vld,
  input logic [DW-AW-1:0] ad_hi,
  input logic [CW-1:0] bus_cmd,
  input logic          bus_cmdp,
  input logic          pend_vld,
  input logic          err,
  input logic          out_vld,
  input logic          out_rdy,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data
);
  wire par_bad = ^{bus_cmd, bus_cmdp};

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R12

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_vld && !(out_vld && out_rdy)) |=>
      ($stable(out_vld) && $stable(out_addr) && $stable(out_data) && $stable(err))); // R2

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_addr) && $stable(out_data))); // R7

  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && par_bad) |=> err); // R5

  AST_UPPER_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !par_bad && !bus_cmd[CW-1] && bus_cmd[CW-2] && (ad_hi != '0)) |=> err); // R4

  AST_ORPHAN_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !par_bad && bus_cmd[CW-1] && !pend_vld) |=> err); // R6
endmodule

bind mbus_wr_capture mbus_wr_capture_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .ad_hi(bus_ad[DW-1:AW]),
  .bus_cmd(bus_cmd), .bus_cmdp(bus_cmdp), .pend_vld(pend_vld), .err(err),
  .out_vld(out_vld), .out_rdy(out_rdy), .out_addr(out_addr), .out_data(out_data)
);

// File: tb/tb_mbus_wr_capture.sv
module tb_mbus_wr_capture;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0;
  logic [63:0] bus_ad = '0;
  logic [8:0]  bus_cmd = '0;
  logic        bus_cmdp = 1'b0;
  logic        out_rdy = 1'b0;
  logic        wr_rdy, err, out_vld;
  logic [35:0] out_addr;
  logic [63:0] out_data;

  mbus_wr_capture dut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_ad(bus_ad),
    .bus_cmd(bus_cmd), .bus_cmdp(bus_cmdp), .wr_rdy(wr_rdy), .err(err),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_addr(out_addr), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [99:0] mq[$];
  logic        m_pend;
  logic [35:0] m_paddr;
  logic        m_err;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic par_of(logic [8:0] c);
    return ^c;
  endfunction

  function automatic logic [8:0] wr_cmd();
    return {2'b01, 7'($urandom)};
  endfunction

  function automatic logic [8:0] dat_cmd();
    return {1'b1, 8'($urandom)};
  endfunction

  function automatic logic [63:0] rnd_addr();
    return {28'h0, 4'($urandom), 32'($urandom)};
  endfunction

  task automatic model_step(logic v, logic [8:0] c, logic p, logic [63:0] ad, logic rdy);
    bit do_pop = (mq.size() != 0) && rdy;
    bit was_full = (mq.size() == DEPTH);
    bit do_push = 0;
    logic [99:0] ent = '0;
    if (v) begin
      if (^{c, p}) m_err = 1'b1;
      else if (!c[8]) begin
        if (c[7]) begin
          if (ad[63:36] != 0) m_err = 1'b1;
          else begin m_pend = 1'b1; m_paddr = ad[35:0]; end
        end
      end else begin
        if (!m_pend || was_full) m_err = 1'b1;
        else begin do_push = 1; ent = {m_paddr, ad}; end
        m_pend = 1'b0;
      end
    end
    if (do_pop) void'(mq.pop_front());
    if (do_push) mq.push_back(ent);
  endtask

  task automatic compare();
    chk("R7 out_vld", 64'(out_vld), 64'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R7 out_addr", 64'(out_addr), 64'(mq[0][99:64]));
      chk("R7 out_data", out_data, mq[0][63:0]);
    end
    chk("R8 wr_rdy", 64'(wr_rdy), 64'(mq.size() < DEPTH - 1));
    chk("R12 err", 64'(err), 64'(m_err));
  endtask

  task automatic step(logic v, logic [8:0] c, logic p, logic [63:0] ad, logic rdy);
    @(negedge clk);
    bus_vld = v; bus_cmd = c; bus_cmdp = p; bus_ad = ad; out_rdy = rdy;
    model_step(v, c, p, ad, rdy);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic wr_addr(logic [63:0] a, logic rdy);
    logic [8:0] c = wr_cmd();
    step(1'b1, c, par_of(c), a, rdy);
  endtask

  task automatic wr_data(logic [63:0] d, logic rdy);
    logic [8:0] c = dat_cmd();
    step(1'b1, c, par_of(c), d, rdy);
  endtask

  task automatic idle(logic rdy);
    step(1'b0, 9'($urandom), 1'($urandom), {$urandom, $urandom}, rdy);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_vld = 1'b0; out_rdy = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mq.delete(); m_pend = 1'b0; m_paddr = '0; m_err = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    #1;
    chk("R1 out_vld", 64'(out_vld), 64'd0);
    chk("R1 wr_rdy", 64'(wr_rdy), 64'd1);
    chk("R1 err", 64'(err), 64'd0);

    // R3 basic pairing
    wr_addr(64'h0000_000A_1234_5678, 1'b0);
    chk("R3 no entry before data", 64'(out_vld), 64'd0);
    wr_data(64'hDEAD_BEEF_0123_4567, 1'b0);
    chk("R3 addr", 64'(out_addr), 64'h0_A123_45678);
    chk("R3 data", out_data, 64'hDEAD_BEEF_0123_4567);
    idle(1'b1);
    chk("R3 drained", 64'(out_vld), 64'd0);

    // R2 strobe low: data beat without strobe must not consume pending address
    wr_addr(64'h0000_0001_0000_0040, 1'b0);
    begin
      logic [8:0] c = dat_cmd();
      step(1'b0, c, par_of(c), 64'h1111, 1'b0);
      chk("R2 no entry", 64'(out_vld), 64'd0);
      chk("R2 err", 64'(err), 64'd0);
    end
    wr_data(64'h2222_3333_4444_5555, 1'b0);
    chk("R2 pending kept addr", 64'(out_addr), 64'h1_0000_0040);
    chk("R2 pending kept data", out_data, 64'h2222_3333_4444_5555);
    idle(1'b1);

    // R10 non-write command leaves pending
    wr_addr(64'h0000_0002_0000_0080, 1'b0);
    begin
      logic [8:0] c = {2'b00, 7'h15};
      step(1'b1, c, par_of(c), 64'h0000_0003_0000_0000, 1'b0);
    end
    wr_data(64'h7, 1'b0);
    chk("R10 addr", 64'(out_addr), 64'h2_0000_0080);
    chk("R10 err", 64'(err), 64'd0);
    idle(1'b1);

    // R4 upper address bits
    do_reset();
    wr_addr(64'h8000_0000_0000_0100, 1'b0);
    chk("R4 err", 64'(err), 64'd1);
    wr_data(64'h9, 1'b0);
    chk("R4 discarded", 64'(out_vld), 64'd0);

    // R5 parity
    do_reset();
    begin
      logic [8:0] c = wr_cmd();
      step(1'b1, c, ~par_of(c), 64'h0000_0000_0000_0200, 1'b0);
    end
    chk("R5 err", 64'(err), 64'd1);
    wr_data(64'hA, 1'b0);
    chk("R5 discarded", 64'(out_vld), 64'd0);

    // R6 orphan data
    do_reset();
    wr_data(64'hB, 1'b0);
    chk("R6 err", 64'(err), 64'd1);
    chk("R6 dropped", 64'(out_vld), 64'd0);

    // R8 / R9 / R7 fill, overflow, ordered drain
    do_reset();
    for (int i = 0; i < 3; i++) begin
      wr_addr(64'(36'h100 + i), 1'b0);
      wr_data(64'(64'hC0 + i), 1'b0);
    end
    chk("R8 wr_rdy at 3", 64'(wr_rdy), 64'd0);
    wr_addr(64'h103, 1'b0);
    wr_data(64'hC3, 1'b0);
    chk("R9 fourth accepted err", 64'(err), 64'd0);
    wr_addr(64'h104, 1'b0);
    wr_data(64'hC4, 1'b0);
    chk("R9 overflow err", 64'(err), 64'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R7 order addr", 64'(out_addr), 64'(36'h100 + i));
      chk("R7 order data", out_data, 64'(64'hC0 + i));
      idle(1'b1);
    end
    chk("R9 nothing extra", 64'(out_vld), 64'd0);

    // R11 simultaneous push and pop
    do_reset();
    wr_addr(64'h200, 1'b0);
    wr_data(64'hD0, 1'b0);
    wr_addr(64'h201, 1'b0);
    wr_data(64'hD1, 1'b1);
    chk("R11 one left", 64'(out_addr), 64'h201);
    idle(1'b1);
    chk("R11 empty", 64'(out_vld), 64'd0);

    // random phase: well-behaved master
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic rdy = ($urandom % 3) != 0;
      if (m_pend) wr_data({$urandom, $urandom}, rdy);
      else if (mq.size() < DEPTH - 1 && ($urandom % 4) != 0) wr_addr(rnd_addr(), rdy);
      else idle(rdy);
    end
    chk("R3 random run no err", 64'(err), 64'd0);

    // random phase: unconstrained beats
    do_reset();
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom % 10;
      logic rdy = ($urandom % 3) != 0;
      logic [8:0] c;
      if (r < 2) idle(rdy);
      else if (r < 5) wr_addr(rnd_addr(), rdy);
      else if (r < 8) wr_data({$urandom, $urandom}, rdy);
      else if (r == 8) begin
        c = {2'b00, 7'($urandom)};
        step(1'b1, c, par_of(c), {$urandom, $urandom}, rdy);
      end else begin
        c = 9'($urandom);
        if ($urandom % 2) step(1'b1, c, ~par_of(c), {$urandom, $urandom}, rdy);
        else step(1'b1, {2'b01, c[6:0]}, par_of({2'b01, c[6:0]}),
                  {4'h1, 28'($urandom), 32'($urandom)}, rdy);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule